// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

This block watches a wide parallel bus of monitor lines (256 by default) and reports, one clock at a time, which lines just showed the edge they were programmed to look for. Every line has its own 2-bit edge-type code and its own mask bit. A line can look for rising edges, falling edges or both. The mask can also silence it completely. The block drives a per-line event vector and a single flag that is high when any line reported an event.

Configuration lives in two banks of 32-bit words behind a simple register port: a one-cycle write strobe and a combinational read. Control words hold sixteen 2-bit codes each. Mask words hold thirty-two mask bits each. The bus is registered once, and each sample is compared against the one before it. A small sequencer with three states holds the outputs quiet after reset until both sample registers carry real bus values. The states are SEQ_LOAD (first sample being taken), SEQ_FILL (previous-sample register being filled) and SEQ_RUN (detection live). The transitions run SEQ_LOAD to SEQ_FILL to SEQ_RUN on consecutive clocks, and the sequencer stays in SEQ_RUN until reset.

Top module: `edge_monitor`

## Requirements
- R1: Lines 0 to NUM_LINES-1 (default 256) are watched independently, and any set of them can report an event in the same cycle.
- R2: Edge code 2'b00 makes a line report only a 0-to-1 transition.
- R3: Edge code 2'b01 makes a line report only a 1-to-0 transition.
- R4: Edge code 2'b10 makes a line report both 0-to-1 and 1-to-0 transitions.
- R5: Edge code 2'b11 is reserved, and a line holding it never reports an event.
- R6: The code for line i sits in control word i/16, at byte offset 0x808 + 4*(i/16), in bits (i%16)*2+1 down to (i%16)*2. Writing one line's code does not change the behaviour of its neighbours.
- R7: The mask bit for line i sits in mask word i/32, at byte offset 0x848 + 4*(i/32), in bit i%32. A 1 suppresses that line's events and a 0 lets them through.
- R8: Suppose a change on mon_in is set up before clock edge k. The matching event bit is then high after edge k+1 for exactly one cycle, and an event is reported only when the two latest samples of a line differ.
- R9: any_evt is high in exactly the cycles in which at least one bit of evt is high.
- R10: Reset clears every control and mask word, which then read back as zero, and clears the sample registers. evt stays zero while the sequencer passes through SEQ_LOAD and SEQ_FILL, even if mon_in is non-zero.
- R11: Reading a control word or a mask word returns the last value written to it.
- R12: A write to an address that is outside both word ranges, or that is not a multiple of 4, changes nothing. A read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_in | input | NUM_LINES | Monitored lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for a write or a read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt | output | NUM_LINES | Per-line event pulse |
| any_evt | output | 1 | OR of all event bits |

## Verification
The assertions assume that mon_in and the register port are driven synchronously to clk. They also assume that a configuration write lands no later than the clock edge at which the affected sample is compared, so that the mask and code seen one cycle earlier are the ones that governed an event. The bench drives every input on the falling edge and leaves at least two full cycles between a configuration write and the bus change it affects. It also holds the bus steady through reset, so that every transition it produces is one it intends.

// File: rtl/edgemon_pkg.sv
package edgemon_pkg;
    localparam int WORD_W         = 32;
    localparam int CODE_W         = 2;
    localparam int LINES_PER_CTRL = WORD_W / CODE_W;
    localparam int LINES_PER_MASK = WORD_W;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_code_e;

    typedef enum logic [1:0] {
        SEQ_LOAD = 2'b00,
        SEQ_FILL = 2'b01,
        SEQ_RUN  = 2'b10
    } seq_state_e;
endpackage

// File: rtl/edgemon_regs.sv
module edgemon_regs
    import edgemon_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int ADDR_W    = 12,
    parameter int CTRL_BASE = 'h808,
    parameter int MASK_BASE = 'h848
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output logic [((NUM_LINES+LINES_PER_CTRL-1)/LINES_PER_CTRL)*WORD_W-1:0] ctrl_flat,
    output logic [((NUM_LINES+LINES_PER_MASK-1)/LINES_PER_MASK)*WORD_W-1:0] mask_flat
);
    localparam int NCTRL = (NUM_LINES + LINES_PER_CTRL - 1) / LINES_PER_CTRL;
    localparam int NMASK = (NUM_LINES + LINES_PER_MASK - 1) / LINES_PER_MASK;
    localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE);
    localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * NCTRL);
    localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_BASE + 4 * NMASK);

    logic [WORD_W-1:0] ctrl_q [NCTRL];
    logic [WORD_W-1:0] mask_q [NMASK];
    logic              aligned;
    logic              ctrl_hit;
    logic              mask_hit;
    logic [ADDR_W-1:0] ctrl_word;
    logic [ADDR_W-1:0] mask_word;

    always_comb begin
        aligned   = (addr[1:0] == 2'b00);
        ctrl_hit  = aligned && (addr >= CTRL_LO) && (addr < CTRL_HI);
        mask_hit  = aligned && (addr >= MASK_LO) && (addr < MASK_HI);
        ctrl_word = (addr - CTRL_LO) >> 2;
        mask_word = (addr - MASK_LO) >> 2;
    end

    for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[g] <= '0;
            end else if (wr_en && ctrl_hit && (ctrl_word == ADDR_W'(g))) begin
                ctrl_q[g] <= wdata;
            end
        end
        assign ctrl_flat[g*WORD_W +: WORD_W] = ctrl_q[g];
    end

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
            end else if (wr_en && mask_hit && (mask_word == ADDR_W'(g))) begin
                mask_q[g] <= wdata;
            end
        end
        assign mask_flat[g*WORD_W +: WORD_W] = mask_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NCTRL; w++) begin
            if (ctrl_hit && (ctrl_word == ADDR_W'(w))) rdata = ctrl_q[w];
        end
        for (int w = 0; w < NMASK; w++) begin
            if (mask_hit && (mask_word == ADDR_W'(w))) rdata = mask_q[w];
        end
    end
endmodule

// File: rtl/edgemon_seq.sv
module edgemon_seq
    import edgemon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LOAD: state_d = SEQ_FILL;
            SEQ_FILL: state_d = SEQ_RUN;
            SEQ_RUN:  state_d = SEQ_RUN;
            default:  state_d = SEQ_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == SEQ_RUN);
    end
endmodule

// File: rtl/edgemon_lane.sv
module edgemon_lane
    import edgemon_pkg::*;
(
    input  logic              cur,
    input  logic              prev,
    input  logic [CODE_W-1:0] code,
    input  logic              masked,
    output logic              hit
);
    logic rise;
    logic fall;
    logic seen;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        unique case (edge_code_e'(code))
            EDGE_RISE: seen = rise;
            EDGE_FALL: seen = fall;
            EDGE_BOTH: seen = rise | fall;
            EDGE_RSVD: seen = 1'b0;
            default:   seen = 1'b0;
        endcase
        hit = seen & ~masked;
    end
endmodule

// File: rtl/edge_monitor.sv
module edge_monitor
    import edgemon_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int ADDR_W    = 12,
    parameter int CTRL_BASE = 'h808,
    parameter int MASK_BASE = 'h848
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] mon_in,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] evt,
    output logic                 any_evt
);
    localparam int NCTRL = (NUM_LINES + LINES_PER_CTRL - 1) / LINES_PER_CTRL;
    localparam int NMASK = (NUM_LINES + LINES_PER_MASK - 1) / LINES_PER_MASK;

    logic [NCTRL*WORD_W-1:0] ctrl_flat;
    logic [NMASK*WORD_W-1:0] mask_flat;
    logic [NUM_LINES-1:0]    samp_q;
    logic [NUM_LINES-1:0]    prev_q;
    logic [NUM_LINES-1:0]    det;
    logic                    run;

    edgemon_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .CTRL_BASE (CTRL_BASE),
        .MASK_BASE (MASK_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ctrl_flat (ctrl_flat),
        .mask_flat (mask_flat)
    );

    edgemon_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        edgemon_lane u_lane (
            .cur    (samp_q[i]),
            .prev   (prev_q[i]),
            .code   (ctrl_flat[(i / LINES_PER_CTRL) * WORD_W + (i % LINES_PER_CTRL) * CODE_W +: CODE_W]),
            .masked (mask_flat[(i / LINES_PER_MASK) * WORD_W + (i % LINES_PER_MASK)]),
            .hit    (det[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q  <= '0;
            prev_q  <= '0;
            evt     <= '0;
            any_evt <= 1'b0;
        end else begin
            samp_q  <= mon_in;
            prev_q  <= samp_q;
            evt     <= run ? det : '0;
            any_evt <= run & (|det);
        end
    end
endmodule

// File: rtl/edgemon_chk.sv
module edgemon_chk
    import edgemon_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int ADDR_W    = 12,
    parameter int CTRL_BASE = 'h808,
    parameter int MASK_BASE = 'h848
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic [NUM_LINES-1:0] evt,
    input logic                 any_evt,
    input logic [NUM_LINES-1:0] samp_q,
    input logic [NUM_LINES-1:0] prev_q,
    input logic [((NUM_LINES+LINES_PER_CTRL-1)/LINES_PER_CTRL)*WORD_W-1:0] ctrl_flat,
    input logic [((NUM_LINES+LINES_PER_MASK-1)/LINES_PER_MASK)*WORD_W-1:0] mask_flat
);
    localparam int NCTRL = (NUM_LINES + LINES_PER_CTRL - 1) / LINES_PER_CTRL;
    localparam int NMASK = (NUM_LINES + LINES_PER_MASK - 1) / LINES_PER_MASK;
    localparam logic [ADDR_W-1:0] C_SPAN = ADDR_W'(4 * NCTRL);
    localparam logic [ADDR_W-1:0] M_SPAN = ADDR_W'(4 * NMASK);

    logic [NUM_LINES-1:0] rsvd_lines;
    logic [NUM_LINES-1:0] line_mask;
    logic [ADDR_W-1:0]    c_rel;
    logic [ADDR_W-1:0]    m_rel;
    logic                 in_map;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_view
        assign rsvd_lines[i] = &ctrl_flat[(i / LINES_PER_CTRL) * WORD_W + (i % LINES_PER_CTRL) * CODE_W +: CODE_W];
        assign line_mask[i]  = mask_flat[(i / LINES_PER_MASK) * WORD_W + (i % LINES_PER_MASK)];
    end

    always_comb begin
        c_rel  = reg_addr - ADDR_W'(CTRL_BASE);
        m_rel  = reg_addr - ADDR_W'(MASK_BASE);
        in_map = (reg_addr[1:0] == 2'b00) && ((c_rel < C_SPAN) || (m_rel < M_SPAN));
    end

    AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n) any_evt == (|evt)); // R9
    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (evt == '0)); // R10
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (evt & $past(line_mask)) == '0); // R7
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (evt & $past(rsvd_lines)) == '0); // R5
    AST_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) (evt & ~($past(samp_q) ^ $past(prev_q))) == '0); // R8
    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !in_map |-> (reg_rdata == '0)); // R12
endmodule

bind edge_monitor edgemon_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .MASK_BASE (MASK_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .evt       (evt),
    .any_evt   (any_evt),
    .samp_q    (samp_q),
    .prev_q    (prev_q),
    .ctrl_flat (ctrl_flat),
    .mask_flat (mask_flat)
);

// File: tb/sim_edge_monitor.sv
module sim_edge_monitor;
    localparam int NL = 256;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] mon;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NL-1:0] evt;
    logic          any_evt;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    edge_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_in    (mon),
        .reg_wr_en (wr_en),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .evt       (evt),
        .any_evt   (any_evt)
    );

    function automatic logic [NL-1:0] bitv(int i);
        return NL'(1) << i;
    endfunction

    task automatic chk_vec(string req, string what, logic [NL-1:0] act, logic [NL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_word(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // drive a new bus value and check the event pulse one cycle after it is sampled
    task automatic drive(logic [NL-1:0] v, logic [NL-1:0] exp, string req);
        @(negedge clk);
        mon = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk_vec(req, "event vector", evt, exp);
        chk_word("R9", "any flag", {31'b0, any_evt}, {31'b0, |exp});
        @(negedge clk);
        chk_vec(req, "pulse ends", evt, '0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        mon   = '1;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk_vec("R10", "quiet after reset", evt, '0);
        end
        reg_rd('h808, d);
        chk_word("R10", "control word 0 cleared", d, '0);
        reg_rd('h864, d);
        chk_word("R10", "mask word 7 cleared", d, '0);
        drive('0, '0, "R2");
        repeat (2) @(negedge clk);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        reg_wr('h814, 32'hA5A5_1234);
        reg_rd('h814, d);
        chk_word("R11", "control word 3", d, 32'hA5A5_1234);
        reg_wr('h864, 32'h8000_0001);
        reg_rd('h864, d);
        chk_word("R11", "mask word 7", d, 32'h8000_0001);
        reg_wr('h814, '0);
        reg_wr('h864, '0);
    endtask

    task automatic t_rise();
        drive(bitv(5), bitv(5), "R2");
        drive('0, '0, "R2");
    endtask

    task automatic t_fall();
        // line 20 -> word 1, bits 9:8 = 01
        reg_wr('h80C, 32'h0000_0100);
        drive(bitv(20), '0, "R3");
        drive('0, bitv(20), "R3");
        drive(bitv(21), bitv(21), "R6");
        drive('0, '0, "R6");
        reg_wr('h80C, '0);
    endtask

    task automatic t_both();
        // line 255 -> word 15, bits 31:30 = 10
        reg_wr('h844, 32'h8000_0000);
        drive(bitv(255), bitv(255), "R4");
        drive('0, bitv(255), "R4");
        reg_wr('h844, '0);
    endtask

    task automatic t_rsvd();
        // line 40 -> word 2, bits 17:16 = 11
        reg_wr('h810, 32'h0003_0000);
        drive(bitv(40), '0, "R5");
        drive('0, '0, "R5");
        reg_wr('h810, '0);
    endtask

    task automatic t_mask();
        // line 70 -> mask word 2, bit 6
        reg_wr('h850, 32'h0000_0040);
        drive(bitv(70) | bitv(71), bitv(71), "R7");
        drive('0, '0, "R7");
        reg_wr('h850, '0);
        drive(bitv(70), bitv(70), "R7");
        drive('0, '0, "R7");
    endtask

    task automatic t_wide();
        logic [NL-1:0] v;
        v = bitv(0) | bitv(128) | bitv(255);
        drive(v, v, "R1");
        drive('0, '0, "R1");
    endtask

    task automatic t_latency();
        // a pulse one cycle wide on the bus still produces exactly one event
        @(negedge clk);
        mon = bitv(9);
        @(negedge clk);
        mon = '0;
        chk_vec("R8", "not yet visible", evt, '0);
        @(negedge clk);
        chk_vec("R8", "event one cycle after sample", evt, bitv(9));
        @(negedge clk);
        chk_vec("R8", "single cycle", evt, '0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_bad_addr();
        logic [31:0] d;
        reg_wr('h80A, 32'hFFFF_FFFF);
        reg_rd('h808, d);
        chk_word("R12", "unaligned write ignored", d, '0);
        reg_rd('h80A, d);
        chk_word("R12", "unaligned read zero", d, '0);
        reg_wr('h868, 32'hFFFF_FFFF);
        reg_rd('h868, d);
        chk_word("R12", "past mask range reads zero", d, '0);
        reg_rd('h864, d);
        chk_word("R12", "mask word 7 untouched", d, '0);
        reg_wr('h000, 32'hFFFF_FFFF);
        reg_rd('h000, d);
        chk_word("R12", "low hole reads zero", d, '0);
        drive(bitv(0), bitv(0), "R12");
        drive('0, '0, "R12");
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_rise();
        t_fall();
        t_both();
        t_rsvd();
        t_mask();
        t_wide();
        t_latency();
        t_bad_addr();
        summary();
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end
endmodule